// File: doc/BRIEF.md
# UART Host Register Interface

This block sits between a host bus and the serial engine of an asynchronous serial controller. It decodes a three-way chip select, holds a register address in a strobe-gated address latch, and steers byte reads and writes to eight register offsets. Line, interrupt-enable, modem control, scratch and divisor values are held here and presented to the serial engine on plain output ports. Received bytes, line status, modem status and the interrupt code come back from the engine on input ports.

Bit 7 of the line control register switches offsets 0 and 1 between two views. When the bit is clear they reach the data path and the interrupt-enable register. When it is set they reach the two divisor bytes. A functional master reset returns the control registers to their initial values and leaves the data and divisor bytes untouched. The separate asynchronous reset `rst_n` clears everything.

Top module: `uart_host_regs`

## Requirements
- R1: The block is selected only when `sel_a`=1, `sel_b`=1 and `sel_n`=0 together. When it is not selected, writes change no register and `rdata` is 0x00.
- R2: A read is enabled when the block is selected and either `rd_hi`=1 or `rd_lo_n`=0. While a read is enabled, `rdata` combinationally shows the addressed register. Otherwise `rdata` is 0x00.
- R3: A write is enabled when the block is selected and either `wr_hi`=1 or `wr_lo_n`=0. Each write cycle, which begins at the first clock on which the write is enabled, updates the addressed register once, at that clock edge.
- R4: While `adr_stb_n`=0, the effective address follows `addr` with no delay.
- R5: While `adr_stb_n`=1, the effective address is the `addr` value sampled at the last clock on which `adr_stb_n` was 0.
- R6: When bit 7 of the line control register is 0, a write to offset 0 loads `tx_hold`, a read of offset 0 returns the receive buffer, and offset 1 reads and writes `int_en`.
- R7: When bit 7 of the line control register is 1, offset 0 reads and writes `div_lo`, and offset 1 reads and writes `div_hi`. `tx_hold` and `int_en` are left unchanged.
- R8: Offset 2 reads {5'b0, `irq_code`, ~`irq_pend`}, offset 5 reads `line_stat`, and offset 6 reads `modem_stat`. Writes to offsets 2, 5 and 6 change no register. Offsets 3, 4 and 7 hold line control, modem control and scratch.
- R9: A write to `tx_hold` (offset 0 with bit 7 clear) makes `tx_load` 1 for exactly the one cycle that follows the write edge.
- R10: The start of a read of offset 0 with bit 7 clear makes `rx_ack` 1 for exactly the one cycle that follows that edge.
- R11: On each clock with `rx_valid`=1, the receive buffer takes `rx_byte`.
- R12: On a clock with `mst_rst`=1, line control, interrupt-enable, modem control and scratch become 0x00 and no pulse is raised. `tx_hold`, `div_lo`, `div_hi` and the receive buffer keep their contents.
- R13: While `rst_n`=0, all registers are 0x00, both pulses are 0, and offset 2 reads 0x01 when `irq_pend`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mst_rst | input | 1 | Functional master reset, active high, synchronous |
| addr | input | 3 | Register offset |
| adr_stb_n | input | 1 | Address strobe, active low; the latch is transparent while it is low |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_n | input | 1 | Chip select, active low |
| rd_hi | input | 1 | Read enable, active high |
| rd_lo_n | input | 1 | Read enable, active low |
| wr_hi | input | 1 | Write enable, active high |
| wr_lo_n | input | 1 | Write enable, active low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0x00 when no read is enabled |
| rx_valid | input | 1 | Received byte is valid |
| rx_byte | input | 8 | Received byte from the serial engine |
| irq_pend | input | 1 | Interrupt pending, from the engine |
| irq_code | input | 2 | Interrupt source code, from the engine |
| line_stat | input | 8 | Line status from the engine |
| modem_stat | input | 8 | Modem status from the engine |
| line_ctl | output | 8 | Line control register |
| int_en | output | 8 | Interrupt-enable register |
| modem_ctl | output | 8 | Modem control register |
| div_lo | output | 8 | Divisor low byte |
| div_hi | output | 8 | Divisor high byte |
| tx_hold | output | 8 | Transmit holding register |
| tx_load | output | 1 | One-cycle pulse after a transmit holding write |
| rx_ack | output | 1 | One-cycle pulse after a receive buffer read |

## Verification
The bench builds the block with its default 8-bit data width and 3-bit address. At that width the access bit sits at bit 7, and all eight offsets, including the overlaid pairs, can be reached in both views. Because the address is only three bits wide, the bench can drive each offset under both strobe states and both polarities of the read and write inputs. The same narrow space lets it try each of the three select inputs alone as the one that is missing.

// File: rtl/uhr_pkg.sv
`timescale 1ns/1ps
package uhr_pkg;
  localparam int unsigned OFS_W = 3;
  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_IEN  = 3'd1;
  localparam logic [OFS_W-1:0] OFS_IID  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_LCTL = 3'd3;
  localparam logic [OFS_W-1:0] OFS_MCTL = 3'd4;
  localparam logic [OFS_W-1:0] OFS_LSTS = 3'd5;
  localparam logic [OFS_W-1:0] OFS_MSTS = 3'd6;
  localparam logic [OFS_W-1:0] OFS_SCR  = 3'd7;
  localparam int unsigned IRQ_CODE_W = 2;
endpackage

// File: rtl/uhr_addr_latch.sv
`timescale 1ns/1ps
module uhr_addr_latch #(
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_eff
);
  logic [AW-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (!stb_n) hold_d = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign addr_eff = stb_n ? hold_q : addr_in;

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_n |=> (hold_q == $past(hold_q)));
endmodule

// File: rtl/uhr_access.sv
`timescale 1ns/1ps
module uhr_access (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_a,
  input  logic sel_b,
  input  logic sel_n,
  input  logic rd_hi,
  input  logic rd_lo_n,
  input  logic wr_hi,
  input  logic wr_lo_n,
  output logic rd_en,
  output logic rd_go,
  output logic wr_go
);
  logic picked, wr_en;
  logic rd_q, wr_q;

  always_comb begin
    picked = sel_a & sel_b & ~sel_n;
    rd_en  = picked & (rd_hi | ~rd_lo_n);
    wr_en  = picked & (wr_hi | ~wr_lo_n);
    rd_go  = rd_en & ~rd_q;
    wr_go  = wr_en & ~wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_en;
      wr_q <= wr_en;
    end
  end

  // R3
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !wr_go);
endmodule

// File: rtl/uhr_regfile.sv
`timescale 1ns/1ps
module uhr_regfile
  import uhr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mst_rst,
  input  logic [OFS_W-1:0]      ofs,
  input  logic                  wr_go,
  input  logic                  rd_en,
  input  logic                  rd_go,
  input  logic [DW-1:0]         wdata,
  input  logic                  rx_valid,
  input  logic [DW-1:0]         rx_byte,
  input  logic                  irq_pend,
  input  logic [IRQ_CODE_W-1:0] irq_code,
  input  logic [DW-1:0]         line_stat,
  input  logic [DW-1:0]         modem_stat,
  output logic [DW-1:0]         rdata,
  output logic [DW-1:0]         line_ctl,
  output logic [DW-1:0]         int_en,
  output logic [DW-1:0]         modem_ctl,
  output logic [DW-1:0]         div_lo,
  output logic [DW-1:0]         div_hi,
  output logic [DW-1:0]         tx_hold,
  output logic                  tx_load,
  output logic                  rx_ack
);
  localparam int unsigned ACC_BIT = DW - 1;
  localparam int unsigned IID_PAD = DW - IRQ_CODE_W - 1;

  logic [DW-1:0] lc_q, ie_q, mc_q, sc_q, dl_q, dh_q, th_q, rb_q;
  logic [DW-1:0] lc_d, ie_d, mc_d, sc_d, dl_d, dh_d, th_d, rb_d;
  logic          tl_q, tl_d, ak_q, ak_d;
  logic          acc;

  always_comb begin
    acc  = lc_q[ACC_BIT];
    lc_d = lc_q; ie_d = ie_q; mc_d = mc_q; sc_d = sc_q;
    dl_d = dl_q; dh_d = dh_q; th_d = th_q; rb_d = rb_q;
    tl_d = 1'b0; ak_d = 1'b0;
    if (mst_rst) begin
      lc_d = '0; ie_d = '0; mc_d = '0; sc_d = '0;
    end else begin
      if (wr_go) begin
        unique case (ofs)
          OFS_DATA: if (acc) dl_d = wdata; else th_d = wdata;
          OFS_IEN:  if (acc) dh_d = wdata; else ie_d = wdata;
          OFS_LCTL: lc_d = wdata;
          OFS_MCTL: mc_d = wdata;
          OFS_SCR:  sc_d = wdata;
          default:  ;
        endcase
      end
      tl_d = wr_go & (ofs == OFS_DATA) & ~acc;
      ak_d = rd_go & (ofs == OFS_DATA) & ~acc;
    end
    if (rx_valid) rb_d = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_q <= '0; ie_q <= '0; mc_q <= '0; sc_q <= '0;
      dl_q <= '0; dh_q <= '0; th_q <= '0; rb_q <= '0;
      tl_q <= 1'b0; ak_q <= 1'b0;
    end else begin
      lc_q <= lc_d; ie_q <= ie_d; mc_q <= mc_d; sc_q <= sc_d;
      dl_q <= dl_d; dh_q <= dh_d; th_q <= th_d; rb_q <= rb_d;
      tl_q <= tl_d; ak_q <= ak_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (ofs)
        OFS_DATA: rdata = acc ? dl_q : rb_q;
        OFS_IEN:  rdata = acc ? dh_q : ie_q;
        OFS_IID:  rdata = {{IID_PAD{1'b0}}, irq_code, ~irq_pend};
        OFS_LCTL: rdata = lc_q;
        OFS_MCTL: rdata = mc_q;
        OFS_LSTS: rdata = line_stat;
        OFS_MSTS: rdata = modem_stat;
        default:  rdata = sc_q;
      endcase
    end
  end

  assign line_ctl = lc_q; assign int_en = ie_q; assign modem_ctl = mc_q;
  assign div_lo = dl_q;   assign div_hi = dh_q; assign tx_hold = th_q;
  assign tx_load = tl_q;  assign rx_ack = ak_q;

  // R12
  mst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mst_rst |=> ($stable(dl_q) && $stable(dh_q) && $stable(th_q)));
  // R12
  mst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mst_rst |=> (lc_q == '0 && ie_q == '0 && mc_q == '0 && sc_q == '0 && !tl_q));
  // R9
  tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tl_q |=> !tl_q);
  // R10
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ak_q |=> !ak_q);
  // R6
  tx_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tl_q |-> !lc_q[ACC_BIT]);
  // R8
  ro_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mst_rst && wr_go && (ofs == OFS_IID || ofs == OFS_LSTS || ofs == OFS_MSTS))
    |=> ($stable(lc_q) && $stable(ie_q) && $stable(mc_q) && $stable(sc_q)
         && $stable(dl_q) && $stable(dh_q) && $stable(th_q)));
endmodule

// File: rtl/uart_host_regs.sv
`timescale 1ns/1ps
module uart_host_regs
  import uhr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mst_rst,
  input  logic [OFS_W-1:0]      addr,
  input  logic                  adr_stb_n,
  input  logic                  sel_a,
  input  logic                  sel_b,
  input  logic                  sel_n,
  input  logic                  rd_hi,
  input  logic                  rd_lo_n,
  input  logic                  wr_hi,
  input  logic                  wr_lo_n,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  input  logic                  rx_valid,
  input  logic [DW-1:0]         rx_byte,
  input  logic                  irq_pend,
  input  logic [IRQ_CODE_W-1:0] irq_code,
  input  logic [DW-1:0]         line_stat,
  input  logic [DW-1:0]         modem_stat,
  output logic [DW-1:0]         line_ctl,
  output logic [DW-1:0]         int_en,
  output logic [DW-1:0]         modem_ctl,
  output logic [DW-1:0]         div_lo,
  output logic [DW-1:0]         div_hi,
  output logic [DW-1:0]         tx_hold,
  output logic                  tx_load,
  output logic                  rx_ack
);
  logic [OFS_W-1:0] ofs;
  logic rd_en, rd_go, wr_go;

  uhr_addr_latch #(.AW(OFS_W)) u_alat (
    .clk(clk), .rst_n(rst_n), .stb_n(adr_stb_n), .addr_in(addr), .addr_eff(ofs));

  uhr_access u_acc (
    .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b), .sel_n(sel_n),
    .rd_hi(rd_hi), .rd_lo_n(rd_lo_n), .wr_hi(wr_hi), .wr_lo_n(wr_lo_n),
    .rd_en(rd_en), .rd_go(rd_go), .wr_go(wr_go));

  uhr_regfile #(.DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n), .mst_rst(mst_rst), .ofs(ofs), .wr_go(wr_go),
    .rd_en(rd_en), .rd_go(rd_go), .wdata(wdata), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .irq_pend(irq_pend), .irq_code(irq_code),
    .line_stat(line_stat), .modem_stat(modem_stat), .rdata(rdata),
    .line_ctl(line_ctl), .int_en(int_en), .modem_ctl(modem_ctl),
    .div_lo(div_lo), .div_hi(div_hi), .tx_hold(tx_hold),
    .tx_load(tx_load), .rx_ack(rx_ack));

  // R1
  always_comb begin
    if (!(sel_a && sel_b && !sel_n)) begin
      unsel_quiet_chk: assert (rdata == '0);
    end
  end
endmodule

// File: tb/sim_uart_host_regs.sv
`timescale 1ns/1ps
module sim_uart_host_regs;
  logic clk = 1'b0;
  logic rst_n, mst_rst, adr_stb_n, sel_a, sel_b, sel_n;
  logic rd_hi, rd_lo_n, wr_hi, wr_lo_n, rx_valid, irq_pend;
  logic [2:0] addr;
  logic [1:0] irq_code;
  logic [7:0] wdata, rx_byte, line_stat, modem_stat;
  logic [7:0] rdata, line_ctl, int_en, modem_ctl, div_lo, div_hi, tx_hold;
  logic tx_load, rx_ack;

  int checks = 0;
  int errors = 0;
  logic last_load, last_ack;

  always #2 clk = ~clk;

  uart_host_regs u0 (.*);

  // behavioural reference
  logic [7:0] m_lc, m_ie, m_mc, m_sc, m_dl, m_dh, m_th, m_rb;
  logic [2:0] m_al, m_ea;
  logic m_wq, m_rq, m_tl, m_ak, m_sel, m_we, m_re, m_wg, m_rg, m_acc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lc = 0; m_ie = 0; m_mc = 0; m_sc = 0; m_dl = 0; m_dh = 0; m_th = 0; m_rb = 0;
      m_al = 0; m_wq = 0; m_rq = 0; m_tl = 0; m_ak = 0;
    end else begin
      m_ea  = adr_stb_n ? m_al : addr;
      m_sel = sel_a && sel_b && !sel_n;
      m_we  = m_sel && (wr_hi || !wr_lo_n);
      m_re  = m_sel && (rd_hi || !rd_lo_n);
      m_wg  = m_we && !m_wq;
      m_rg  = m_re && !m_rq;
      m_wq  = m_we; m_rq = m_re;
      if (!adr_stb_n) m_al = addr;
      m_acc = m_lc[7];
      m_tl = 0; m_ak = 0;
      if (mst_rst) begin
        m_lc = 0; m_ie = 0; m_mc = 0; m_sc = 0;
      end else begin
        if (m_wg) begin
          case (m_ea)
            0: if (m_acc) m_dl = wdata; else m_th = wdata;
            1: if (m_acc) m_dh = wdata; else m_ie = wdata;
            3: m_lc = wdata;
            4: m_mc = wdata;
            7: m_sc = wdata;
            default: ;
          endcase
        end
        m_tl = m_wg && m_ea == 0 && !m_acc;
        m_ak = m_rg && m_ea == 0 && !m_acc;
      end
      if (rx_valid) m_rb = rx_byte;
    end
  end

  function automatic logic [7:0] m_rdata();
    logic [2:0] ea;
    ea = adr_stb_n ? m_al : addr;
    if (!(sel_a && sel_b && !sel_n && (rd_hi || !rd_lo_n))) return 8'h00;
    case (ea)
      0: return m_lc[7] ? m_dl : m_rb;
      1: return m_lc[7] ? m_dh : m_ie;
      2: return {5'b0, irq_code, ~irq_pend};
      3: return m_lc;
      4: return m_mc;
      5: return line_stat;
      6: return modem_stat;
      default: return m_sc;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 rdata vs model", rdata, m_rdata());
      chk("R3 line_ctl vs model", line_ctl, m_lc);
      chk("R6 int_en vs model", int_en, m_ie);
      chk("R8 modem_ctl vs model", modem_ctl, m_mc);
      chk("R7 div_lo vs model", div_lo, m_dl);
      chk("R7 div_hi vs model", div_hi, m_dh);
      chk("R6 tx_hold vs model", tx_hold, m_th);
      chk("R9 tx_load vs model", {7'b0, tx_load}, {7'b0, m_tl});
      chk("R10 rx_ack vs model", {7'b0, rx_ack}, {7'b0, m_ak});
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    sel_a = 1; sel_b = 1; sel_n = 0;
    rd_hi = 0; rd_lo_n = 1; wr_hi = 0; wr_lo_n = 1;
  endtask

  // a < 0 leaves addr and strobe as they are; pol 0 uses the high input, 1 the low one
  task automatic wr(int a, logic [7:0] d, bit pol = 0, logic [2:0] sels = 3'b110);
    tick();
    if (a >= 0) begin addr = a[2:0]; adr_stb_n = 0; end
    wdata = d;
    {sel_a, sel_b, sel_n} = sels;
    if (pol) wr_lo_n = 0; else wr_hi = 1;
    @(negedge clk);
    last_load = tx_load;
    #1 idle();
  endtask

  task automatic rd(int a, logic [7:0] exp, string tag, bit pol = 0, logic [2:0] sels = 3'b110);
    tick();
    addr = a[2:0]; adr_stb_n = 0;
    {sel_a, sel_b, sel_n} = sels;
    if (pol) rd_lo_n = 0; else rd_hi = 1;
    @(negedge clk);
    chk(tag, rdata, exp);
    last_ack = rx_ack;
    #1 idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; mst_rst = 0; adr_stb_n = 0; addr = 0; wdata = 0;
    rx_valid = 0; rx_byte = 0; irq_pend = 0; irq_code = 0;
    line_stat = 8'h60; modem_stat = 8'hB0;
    idle();
    repeat (3) @(posedge clk);
    #1;
    chk("R13 line_ctl in reset", line_ctl, 8'h00);
    chk("R13 tx_load in reset", {7'b0, tx_load}, 8'h00);
    @(negedge clk); rst_n = 1;
    rd(2, 8'h01, "R13 IID idle value");

    // R3 dual polarity writes, R2 dual polarity reads
    wr(3, 8'h03);
    rd(3, 8'h03, "R2 R3 high-polarity access");
    wr(4, 8'h15, 1);
    rd(4, 8'h15, "R2 R3 low-polarity access", 1);
    wr(7, 8'hA5);
    // R3 write held over several cycles updates once (register visible at once)
    tick(); addr = 7; wdata = 8'h5A; wr_hi = 1;
    tick(); wdata = 8'h77; tick(); idle();
    rd(7, 8'h5A, "R3 held write takes first-cycle data");

    // R1 each select missing
    wr(7, 8'h11, 0, 3'b010);
    wr(7, 8'h22, 0, 3'b100);
    wr(7, 8'h33, 0, 3'b111);
    rd(7, 8'h00, "R1 read while deselected", 0, 3'b011);
    rd(7, 8'h5A, "R1 deselected writes ignored");

    // R6 data view
    wr(0, 8'hC3);
    chk("R9 tx_load after holding write", {7'b0, last_load}, 8'h01);
    chk("R6 tx_hold loaded", tx_hold, 8'hC3);
    wr(1, 8'h0F);
    rd(1, 8'h0F, "R6 int_en at offset 1");

    // R7 divisor view
    wr(3, 8'h83);
    wr(0, 8'h34);
    chk("R9 no pulse for divisor write", {7'b0, last_load}, 8'h00);
    wr(1, 8'h12);
    chk("R7 div_lo", div_lo, 8'h34);
    chk("R7 div_hi", div_hi, 8'h12);
    chk("R7 tx_hold untouched", tx_hold, 8'hC3);
    rd(1, 8'h12, "R7 div_hi read");
    chk("R7 int_en untouched", int_en, 8'h0F);

    // R4 and R5 address latch
    tick(); addr = 7; adr_stb_n = 0;
    tick(); adr_stb_n = 1; addr = 3;
    wr(-1, 8'h9C);
    rd(7, 8'h9C, "R5 latched offset took write");
    rd(3, 8'h83, "R5 live offset untouched");
    rd(6, 8'hB0, "R4 transparent offset 6");
    rd(5, 8'h60, "R4 transparent offset 5");

    // R8 read-only offsets
    irq_pend = 1; irq_code = 2'b10;
    rd(2, 8'h04, "R8 IID from engine");
    wr(2, 8'hFF); wr(5, 8'hFF); wr(6, 8'hFF);
    rd(3, 8'h83, "R8 read-only writes ignored");
    irq_pend = 0; irq_code = 0;

    // R11 R10 receive path
    wr(3, 8'h03);
    tick(); rx_valid = 1; rx_byte = 8'h6E;
    tick(); rx_valid = 0; rx_byte = 8'hFF;
    rd(0, 8'h6E, "R11 receive buffer captured");
    chk("R10 rx_ack pulse", {7'b0, last_ack}, 8'h01);
    tick();
    chk("R10 rx_ack one cycle", {7'b0, rx_ack}, 8'h00);

    // R12 master reset
    wr(0, 8'h4D);
    tick(); mst_rst = 1; tick(); mst_rst = 0;
    chk("R12 line_ctl cleared", line_ctl, 8'h00);
    chk("R12 int_en cleared", int_en, 8'h00);
    chk("R12 modem_ctl cleared", modem_ctl, 8'h00);
    rd(7, 8'h00, "R12 scratch cleared");
    chk("R12 tx_hold kept", tx_hold, 8'h4D);
    chk("R12 div_lo kept", div_lo, 8'h34);
    chk("R12 div_hi kept", div_hi, 8'h12);
    rd(0, 8'h6E, "R12 receive buffer kept");

    // R13 full reset
    tick(); rst_n = 0; #1;
    chk("R13 div_lo cleared", div_lo, 8'h00);
    chk("R13 tx_hold cleared", tx_hold, 8'h00);
    tick(); rst_n = 1;
    rd(0, 8'h00, "R13 receive buffer cleared");
    tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule